// File: doc/BRIEF.md
# Maximum Value and Index Finder

The block looks at eight unsigned values packed side by side on one input vector and reports the largest value together with the position it came from. Position 0 is the least significant field of the vector. When several fields hold the largest value, the lowest position is reported. Signed comparison is not supported.

A parameter picks one of two variants. The tree variant is built from compare-select cells arranged as a binary tree of three levels: four cells, then two, then one. Each cell forwards the larger value and that value's position. With pipelining enabled there is a register after every level, so a new vector can be accepted on every clock and each result follows three cycles later. With pipelining disabled, only the final result is registered. The scan variant stores the vector when a scan starts. It then examines one field per cycle, keeping a running best value and position, and raises a one-cycle completion pulse after the last field has been examined.

Top module: `max_index_finder`

## Requirements
- R1: `out_max` equals the largest of the eight unsigned `W`-bit fields, where field i occupies `in_data[i*W +: W]`, and `out_idx` is the position of that field. This holds in every variant.
- R2: When two or more fields share the largest value, `out_idx` reports the lowest of their positions. This holds in every variant.
- R3: Tree variant with pipelining (`SEQ=0`, `PIPE=1`): a vector presented with `in_valid` high is accepted on every clock. Its result appears with `out_valid` high exactly three clock edges after the edge that sampled it, and `out_valid` is low for every cycle that had `in_valid` low.
- R4: Tree variant without pipelining (`SEQ=0`, `PIPE=0`): the result and `out_valid` appear one clock edge after the edge that sampled the input.
- R5: Scan variant (`SEQ=1`): `in_valid` sampled high while idle starts a scan and stores the vector. `out_valid` goes high for exactly one cycle, following the eighth clock edge after the starting edge, and is low during the scan.
- R6: Scan variant: `in_valid` raised during a scan is ignored. The result is that of the stored vector, and its timing and the single completion pulse are unchanged.
- R7: Scan variant: the running best is cleared to zero at the start of every scan, so a result never depends on the values seen in an earlier scan.
- R8: A vector whose fields are all zero gives `out_max` = 0 and `out_idx` = 0.
- R9: After reset, `out_valid` is low until a vector has been accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Vector valid (tree) or scan start (scan) |
| in_data | input | N*W | Eight packed unsigned fields, field i at bits i*W +: W |
| out_valid | output | 1 | Result valid (tree) or one-cycle completion pulse (scan) |
| out_max | output | W | Largest field value |
| out_idx | output | $clog2(N) | Position of the largest field |

## Verification
The bench targets ties: every pair of positions sharing the top value, all fields equal, and all zero. A cell that let the upper operand win on equality would report the higher position. It also streams vectors back to back with gaps in `in_valid`. A pipeline with a valid shift register of the wrong length would flag results a cycle early or late, or flag a bubble. For the scan variant, a second start is driven part-way through a scan, and a scan of small values is run directly after a scan of large ones. A design that restarted on the second start would miss the expected completion cycle, and one that kept the old best would report a stale large value.

// File: rtl/mxf_pkg.sv
package mxf_pkg;

  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_state_e;

  // cycles from input sample to registered result in the tree variant
  function automatic int unsigned tree_latency(int unsigned levels, bit pipe);
    return pipe ? levels : 1;
  endfunction

endpackage

// File: rtl/mxf_cell.sv
module mxf_cell #(
  parameter int unsigned W  = 8,
  parameter int unsigned IW = 3
) (
  input  logic [W-1:0]  lo_v,
  input  logic [IW-1:0] lo_i,
  input  logic [W-1:0]  hi_v,
  input  logic [IW-1:0] hi_i,
  output logic [W-1:0]  win_v,
  output logic [IW-1:0] win_i
);

  // the operand from the upper positions wins only when strictly larger
  function automatic logic upper_beats(logic [W-1:0] low, logic [W-1:0] high);
    return high > low;
  endfunction

  logic hi_wins;
  assign hi_wins = upper_beats(lo_v, hi_v);
  assign win_v   = hi_wins ? hi_v : lo_v;
  assign win_i   = hi_wins ? hi_i : lo_i;

endmodule

// File: rtl/mxf_tree.sv
module mxf_tree #(
  parameter int unsigned N    = 8,
  parameter int unsigned W    = 8,
  parameter bit          PIPE = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [N*W-1:0]          in_data,
  output logic                    out_valid,
  output logic [W-1:0]            out_max,
  output logic [$clog2(N)-1:0]    out_idx
);
  import mxf_pkg::*;

  localparam int unsigned IW     = $clog2(N);
  localparam int unsigned LEVELS = $clog2(N);
  localparam int unsigned NODES  = 2 * N - 1;
  localparam int unsigned LAT    = tree_latency(LEVELS, PIPE);

  // heap-ordered nodes: node k has children 2k+1 (lower positions) and 2k+2
  logic [W-1:0]  node_v [NODES];
  logic [IW-1:0] node_i [NODES];

  for (genvar g = 0; g < N; g++) begin : g_leaf
    assign node_v[N-1+g] = in_data[g*W +: W];
    assign node_i[N-1+g] = IW'(g);
  end

  for (genvar k = 0; k < N - 1; k++) begin : g_node
    logic [W-1:0]  cw_v;
    logic [IW-1:0] cw_i;

    mxf_cell #(.W(W), .IW(IW)) u_cell (
      .lo_v  (node_v[2*k+1]),
      .lo_i  (node_i[2*k+1]),
      .hi_v  (node_v[2*k+2]),
      .hi_i  (node_i[2*k+2]),
      .win_v (cw_v),
      .win_i (cw_i)
    );

    if (PIPE || k == 0) begin : g_reg
      logic [W-1:0]  r_v;
      logic [IW-1:0] r_i;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          r_v <= '0;
          r_i <= '0;
        end else begin
          r_v <= cw_v;
          r_i <= cw_i;
        end
      end
      assign node_v[k] = r_v;
      assign node_i[k] = r_i;
    end else begin : g_wire
      assign node_v[k] = cw_v;
      assign node_i[k] = cw_i;
    end
  end

  logic [LAT-1:0] vld_sr;

  if (LAT == 1) begin : g_v1
    always_ff @(posedge clk) begin
      if (!rst_n) vld_sr <= '0;
      else        vld_sr <= in_valid;
    end
  end else begin : g_vn
    always_ff @(posedge clk) begin
      if (!rst_n) vld_sr <= '0;
      else        vld_sr <= {vld_sr[LAT-2:0], in_valid};
    end
  end

  assign out_valid = vld_sr[LAT-1];
  assign out_max   = node_v[0];
  assign out_idx   = node_i[0];

endmodule

// File: rtl/mxf_scan.sv
module mxf_scan #(
  parameter int unsigned N = 8,
  parameter int unsigned W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [N*W-1:0]       in_data,
  output logic                 done,
  output logic [W-1:0]         best_v,
  output logic [$clog2(N)-1:0] best_i,
  output logic                 busy,
  output logic [$clog2(N)-1:0] pos
);
  import mxf_pkg::*;

  localparam int unsigned IW   = $clog2(N);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  // select field p of a packed vector
  function automatic logic [W-1:0] field_at(logic [N*W-1:0] vec, logic [IW-1:0] p);
    logic [W-1:0] f;
    f = '0;
    for (int i = 0; i < N; i++) begin
      if (p == IW'(i)) f = vec[i*W +: W];
    end
    return f;
  endfunction

  scan_state_e        state;
  logic [N*W-1:0]     cap;
  logic [W-1:0]       cur_v;
  logic               take_new;

  assign cur_v    = field_at(cap, pos);
  assign take_new = cur_v > best_v;
  assign busy     = (state == SCAN_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SCAN_IDLE;
      cap    <= '0;
      pos    <= '0;
      best_v <= '0;
      best_i <= '0;
      done   <= 1'b0;
    end else begin
      case (state)
        SCAN_IDLE: begin
          done <= 1'b0;
          if (start) begin
            cap    <= in_data;
            best_v <= '0;
            best_i <= '0;
            pos    <= '0;
            state  <= SCAN_RUN;
          end
        end
        default: begin
          if (take_new) begin
            best_v <= cur_v;
            best_i <= pos;
          end
          if (pos == LAST) begin
            pos   <= '0;
            done  <= 1'b1;
            state <= SCAN_IDLE;
          end else begin
            pos <= pos + IW'(1);
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/max_index_finder.sv
module max_index_finder #(
  parameter int unsigned N    = 8,
  parameter int unsigned W    = 8,
  parameter bit          SEQ  = 1'b0,
  parameter bit          PIPE = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [N*W-1:0]       in_data,
  output logic                 out_valid,
  output logic [W-1:0]         out_max,
  output logic [$clog2(N)-1:0] out_idx
);

  localparam int unsigned IW = $clog2(N);

  // scan progress, brought out for the checker
  logic          scan_busy;
  logic [IW-1:0] scan_pos;

  if (SEQ) begin : g_scan
    mxf_scan #(.N(N), .W(W)) u_scan (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (in_valid),
      .in_data (in_data),
      .done    (out_valid),
      .best_v  (out_max),
      .best_i  (out_idx),
      .busy    (scan_busy),
      .pos     (scan_pos)
    );
  end else begin : g_tree
    mxf_tree #(.N(N), .W(W), .PIPE(PIPE)) u_tree (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_max   (out_max),
      .out_idx   (out_idx)
    );
    assign scan_busy = 1'b0;
    assign scan_pos  = '0;
  end

endmodule

// File: rtl/mxf_checker.sv
module mxf_checker #(
  parameter int unsigned N    = 8,
  parameter int unsigned W    = 8,
  parameter bit          SEQ  = 1'b0,
  parameter bit          PIPE = 1'b1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic [W-1:0]         out_max,
  input logic                 scan_busy,
  input logic [$clog2(N)-1:0] scan_pos
);
  import mxf_pkg::*;

  localparam int unsigned IW  = $clog2(N);
  localparam int unsigned LAT = tree_latency($clog2(N), PIPE);

  // idle means the scan position rests at zero (R5)
  p_idle_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_busy |-> scan_pos == '0);

  // the running best never shrinks within a scan (R1)
  p_best_grows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    scan_busy |=> out_max >= $past(out_max));

  if (SEQ) begin : g_seq
    p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !scan_busy |=> scan_busy && scan_pos == '0);

    p_best_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !scan_busy |=> out_max == '0);

    p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      scan_busy && scan_pos != IW'(N - 1) |=>
        scan_busy && scan_pos == $past(scan_pos) + IW'(1));

    p_finish_r5: assert property (@(posedge clk) disable iff (!rst_n)
      scan_busy && scan_pos == IW'(N - 1) |=> out_valid && !scan_busy);

    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

    p_no_done_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !scan_busy);
  end else begin : g_par
    logic [LAT-1:0] shadow;
    always_ff @(posedge clk) begin
      if (!rst_n) shadow <= '0;
      else        shadow <= LAT'({shadow, in_valid});
    end

    // R3 (pipelined) and R4 (flat): valid follows input by the latency
    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == shadow[LAT-1]);

    p_no_scan_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_busy);
  end

endmodule

bind max_index_finder mxf_checker #(.N(N), .W(W), .SEQ(SEQ), .PIPE(PIPE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_max   (out_max),
  .scan_busy (scan_busy),
  .scan_pos  (scan_pos)
);

// File: tb/max_index_finder_test.sv
module max_index_finder_test;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int W  = 4;
  localparam int IW = 3;
  localparam int MAXV = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          pv, sv;
  logic [N*W-1:0] pd, sd;
  logic          p_ov, f_ov, s_ov;
  logic [W-1:0]  p_mx, f_mx, s_mx;
  logic [IW-1:0] p_ix, f_ix, s_ix;

  max_index_finder #(.N(N), .W(W), .SEQ(1'b0), .PIPE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(pv), .in_data(pd),
    .out_valid(p_ov), .out_max(p_mx), .out_idx(p_ix));

  max_index_finder #(.N(N), .W(W), .SEQ(1'b0), .PIPE(1'b0)) uut_flat (
    .clk(clk), .rst_n(rst_n), .in_valid(pv), .in_data(pd),
    .out_valid(f_ov), .out_max(f_mx), .out_idx(f_ix));

  max_index_finder #(.N(N), .W(W), .SEQ(1'b1), .PIPE(1'b0)) uut_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(sv), .in_data(sd),
    .out_valid(s_ov), .out_max(s_mx), .out_idx(s_ix));

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<=50000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference: walk from the top position down, equal values move the winner lower
  function automatic int ref_val(input logic [N*W-1:0] v);
    int b;
    b = 0;
    for (int i = 0; i < N; i++) if (int'(v[i*W +: W]) > b) b = int'(v[i*W +: W]);
    return b;
  endfunction

  function automatic int ref_idx(input logic [N*W-1:0] v);
    int bi, bv;
    bi = N - 1;
    bv = int'(v[(N-1)*W +: W]);
    for (int i = N - 2; i >= 0; i--) begin
      if (int'(v[i*W +: W]) >= bv) begin
        bv = int'(v[i*W +: W]);
        bi = i;
      end
    end
    return bi;
  endfunction

  logic [N*W-1:0] vecs [0:159];
  logic           vld  [0:169];
  int nvec = 0;

  task automatic push(input logic [N*W-1:0] v);
    vecs[nvec] = v;
    nvec = nvec + 1;
  endtask

  task automatic build_vectors();
    logic [N*W-1:0] v;
    logic [31:0] seed;
    push('0);
    v = '0;
    for (int k = 0; k < N; k++) v[k*W +: W] = W'(MAXV);
    push(v);
    for (int p = 0; p < N; p++) begin
      v = '0;
      for (int k = 0; k < N; k++) v[k*W +: W] = (k == p) ? W'(9) : W'((k + p) % 9);
      push(v);
    end
    for (int i = 0; i < N - 1; i++) begin
      for (int j = i + 1; j < N; j++) begin
        v = '0;
        for (int k = 0; k < N; k++)
          v[k*W +: W] = (k == i || k == j) ? W'(MAXV) : W'((k * 3 + i) % 15);
        push(v);
      end
    end
    seed = 32'h1234_5678;
    for (int r = 0; r < 80; r++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      push(seed);
    end
  endtask

  task automatic check_tree(input string nm, input int s, input int lat,
                            input logic ov, input logic [W-1:0] mx, input logic [IW-1:0] ix);
    int c;
    c = s - lat;
    if (c < 0) begin
      chk({nm, " R9 idle valid"}, int'(ov), 0);
    end else begin
      chk({nm, (lat == 3) ? " R3 valid timing" : " R4 valid timing"}, int'(ov), int'(vld[c]));
      if (vld[c] && c < nvec) begin
        chk({nm, " R1 max value"}, int'(mx), ref_val(vecs[c]));
        chk({nm, " R2 index (lowest on tie)"}, int'(ix), ref_idx(vecs[c]));
        if (vecs[c] == '0) chk({nm, " R8 zero index"}, int'(ix), 0);
      end
    end
  endtask

  task automatic run_scan(input logic [N*W-1:0] v);
    @(negedge clk);
    sv = 1'b1;
    sd = v;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (k <= 8) chk("seq R5 no early done", int'(s_ov), 0);
      if (k == 9) begin
        chk("seq R5/R6 done after eight compares", int'(s_ov), 1);
        chk("seq R1/R7 max value", int'(s_mx), ref_val(v));
        chk("seq R2 index (lowest on tie)", int'(s_ix), ref_idx(v));
        if (v == '0) chk("seq R8 zero value", int'(s_mx), 0);
      end
      if (k == 10) chk("seq R5/R6 single pulse", int'(s_ov), 0);
      sv = 1'b0;
      sd = ~v;
      if (k == 3) sv = 1'b1;  // start during scan must be ignored (R6)
    end
  endtask

  initial begin
    pv = 1'b0; sv = 1'b0; pd = '0; sd = '0;
    build_vectors();
    for (int i = 0; i < 170; i++) vld[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset pipe valid", int'(p_ov), 0);
    chk("R9 reset flat valid", int'(f_ov), 0);
    chk("R9 reset seq valid", int'(s_ov), 0);

    // stream with bubbles into both tree variants
    for (int s = 0; s < nvec + 4; s++) begin
      check_tree("pipe", s, 3, p_ov, p_mx, p_ix);
      check_tree("flat", s, 1, f_ov, f_mx, f_ix);
      if (s < nvec) begin
        vld[s] = (s % 7 != 5);
        pv = vld[s];
        pd = vld[s] ? vecs[s] : ~vecs[s];
      end else begin
        pv = 1'b0;
        pd = '0;
      end
      @(negedge clk);
    end

    // scans: all-max then small values exercises the best-reset (R7)
    for (int i = 0; i < 40; i++) run_scan(vecs[i]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule